// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block keeps a small set of sticky interrupt status bits, one per hardware event source, together with a mask bit for each, and drives one level-sensitive interrupt line. An event input that is high at a clock edge latches its status bit. Software clears status bits by writing ones to the status register. It changes the mask only through two strobe registers: one that unmasks the bits written as one and one that masks them. The mask register itself can be read but not written. The interrupt line is high while any latched status bit has its mask bit clear.

The register port is a single-cycle request bus with valid, write, byte address and 32-bit data. Writes take effect at the clock edge of the request. Reads return data, least significant byte at the lowest address, on the cycle after the request with a one-cycle valid flag. The number of sources is a parameter (default 1). The bench runs a two-source configuration so that bit independence can be swept. A parameter can also place a register on the interrupt output.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset every status bit is 0, every mask bit is 1 (0x1 for one source, 0x3 for two), and irq_o is low.
- R2: With the default combinational output, irq_o is high exactly when some status bit is 1 while its mask bit is 0. It follows the register state in the same cycle as any status, enable or disable update.
- R3: An evt_i bit that is high at a rising clock edge sets the matching status bit, and that bit stays set until software clears it.
- R4: A write to offset 0x00 clears each status bit whose data bit is 1 and leaves the bits written as 0 unchanged. A read of 0x00 returns the status bits in data bits [NUM_SRC-1:0].
- R5: When an event and a status write clear the same bit in the same cycle, the bit ends up set.
- R6: Offset 0x04 returns the mask bits in data bits [NUM_SRC-1:0] on read, and writes to it leave the mask unchanged.
- R7: A write to offset 0x08 clears each mask bit whose data bit is 1. Zero data bits have no effect, and the offset reads as zero.
- R8: A write to offset 0x0C sets each mask bit whose data bit is 1. Zero data bits have no effect, and the offset reads as zero.
- R9: An access with bus_addr_i[1:0] not zero changes no state and reads as zero. Register bits at or above NUM_SRC read as zero.
- R10: Offsets from 0x10 to the top of the address space read as zero, and writes to them change no state.
- R11: Read data appears on bus_rdata_o in the cycle after the read request, with bus_rvld_o high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | Hardware event per source; high at an edge sets status |
| bus_vld_i | input | 1 | Register request valid |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte address of the request |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, one cycle after the request |
| bus_rvld_o | output | 1 | Read data valid |
| irq_o | output | 1 | Level interrupt, status and not mask |

## Verification
The hardest case to reach from the ports is a hardware event and a software clear landing on the same status bit at the same clock edge. Reaching it needs exact cycle alignment between the event pins and the bus. The bench uses one task that drives both in the same cycle. It then reads the status back and checks the interrupt. The other sweeps walk every combination of status and mask for two sources. They set status through event pulses and set the mask through enable and disable writes. From each reached state, every data pattern is applied to the clear, enable and disable registers.

// File: rtl/imsc_pkg.sv
package imsc_pkg;

   // Byte offsets of the register words
   localparam int unsigned OFS_STAT = 0;
   localparam int unsigned OFS_MASK = 4;
   localparam int unsigned OFS_EN   = 8;
   localparam int unsigned OFS_DIS  = 12;

   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_STAT = 3'd1,
      SEL_MASK = 3'd2,
      SEL_EN   = 3'd3,
      SEL_DIS  = 3'd4
   } reg_sel_e;

endpackage

// File: rtl/imsc_decode.sv
module imsc_decode
   import imsc_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              vld_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              wr_stat_o,
   output logic              wr_en_o,
   output logic              wr_dis_o,
   output logic              rd_o,
   output reg_sel_e          rd_sel_o
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   logic             aligned;
   logic [IDX_W-1:0] idx;
   reg_sel_e         sel;

   assign aligned = (addr_i[1:0] == 2'b00);
   assign idx     = addr_i[ADDR_W-1:2];

   always_comb begin
      sel = SEL_NONE;
      if (aligned) begin
         if      (idx == IDX_W'(OFS_STAT / 4)) sel = SEL_STAT;
         else if (idx == IDX_W'(OFS_MASK / 4)) sel = SEL_MASK;
         else if (idx == IDX_W'(OFS_EN / 4))   sel = SEL_EN;
         else if (idx == IDX_W'(OFS_DIS / 4))  sel = SEL_DIS;
      end
   end

   assign wr_stat_o = vld_i && wr_i && (sel == SEL_STAT);
   assign wr_en_o   = vld_i && wr_i && (sel == SEL_EN);
   assign wr_dis_o  = vld_i && wr_i && (sel == SEL_DIS);
   assign rd_o      = vld_i && !wr_i;
   assign rd_sel_o  = sel;

endmodule

// File: rtl/imsc_bit.sv
module imsc_bit #(
   parameter bit MASK_RST = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic evt_i,
   input  logic clr_i,
   input  logic en_i,
   input  logic dis_i,
   output logic stat_o,
   output logic mask_o
);
   logic stat_q, mask_q;

   // Event has priority over the software clear
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q <= 1'b0;
      else         stat_q <= evt_i | (stat_q & ~clr_i);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mask_q <= MASK_RST;
      else if (dis_i)  mask_q <= 1'b1;
      else if (en_i)   mask_q <= 1'b0;
   end

   assign stat_o = stat_q;
   assign mask_o = mask_q;

endmodule

// File: rtl/imsc_rdmux.sv
module imsc_rdmux
   import imsc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 1,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               rd_i,
   input  reg_sel_e           sel_i,
   input  logic [NUM_SRC-1:0] stat_i,
   input  logic [NUM_SRC-1:0] mask_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               rvld_o
);
   logic [DATA_W-1:0] rdata_d, rdata_q;
   logic              rvld_q;

   always_comb begin
      rdata_d = '0;
      if (rd_i) begin
         unique case (sel_i)
            SEL_STAT: rdata_d = DATA_W'(stat_i);
            SEL_MASK: rdata_d = DATA_W'(mask_i);
            default:  rdata_d = '0;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_q <= '0;
         rvld_q  <= 1'b0;
      end else begin
         rdata_q <= rdata_d;
         rvld_q  <= rd_i;
      end
   end

   assign rdata_o = rdata_q;
   assign rvld_o  = rvld_q;

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
   import imsc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 1,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 6,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               bus_vld_i,
   input  logic               bus_wr_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   output logic               bus_rvld_o,
   output logic               irq_o
);
   localparam int unsigned MIN_ADDR_W = 4;

   initial begin
      if (NUM_SRC < 1 || NUM_SRC > DATA_W)
         $fatal(1, "irq_mask_ctrl: NUM_SRC must lie in 1..DATA_W");
      if (DATA_W % 8 != 0)
         $fatal(1, "irq_mask_ctrl: DATA_W must be whole bytes");
      if (ADDR_W < MIN_ADDR_W)
         $fatal(1, "irq_mask_ctrl: ADDR_W too small for four words");
   end

   logic               wr_stat, wr_en, wr_dis, rd;
   reg_sel_e           rd_sel;
   logic [NUM_SRC-1:0] stat_q, mask_q;
   logic [NUM_SRC-1:0] wd_lo;
   logic               unused_wdata;
   logic               pend;

   assign wd_lo        = bus_wdata_i[NUM_SRC-1:0];
   assign unused_wdata = ^bus_wdata_i;

   imsc_decode #(.ADDR_W(ADDR_W)) u_dec (
      .vld_i     (bus_vld_i),
      .wr_i      (bus_wr_i),
      .addr_i    (bus_addr_i),
      .wr_stat_o (wr_stat),
      .wr_en_o   (wr_en),
      .wr_dis_o  (wr_dis),
      .rd_o      (rd),
      .rd_sel_o  (rd_sel)
   );

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      imsc_bit #(.MASK_RST(1'b1)) u_bit (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .evt_i  (evt_i[k]),
         .clr_i  (wr_stat & wd_lo[k]),
         .en_i   (wr_en & wd_lo[k]),
         .dis_i  (wr_dis & wd_lo[k]),
         .stat_o (stat_q[k]),
         .mask_o (mask_q[k])
      );
   end

   imsc_rdmux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rd_i    (rd),
      .sel_i   (rd_sel),
      .stat_i  (stat_q),
      .mask_i  (mask_q),
      .rdata_o (bus_rdata_o),
      .rvld_o  (bus_rvld_o)
   );

   assign pend = |(stat_q & ~mask_q);

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= pend;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = pend;
   end

endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
   parameter int unsigned NUM_SRC = 1,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 6
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [NUM_SRC-1:0] evt_i,
   input logic               bus_vld_i,
   input logic               bus_wr_i,
   input logic [ADDR_W-1:0]  bus_addr_i,
   input logic [DATA_W-1:0]  bus_wdata_i,
   input logic               bus_rvld_o,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] stat_q,
   input logic [NUM_SRC-1:0] mask_q
);
   logic [NUM_SRC-1:0] wlo;
   logic wr_any, w_stat, w_mask, w_en, w_dis, w_odd, rd_req;

   assign wlo    = bus_wdata_i[NUM_SRC-1:0];
   assign wr_any = bus_vld_i && bus_wr_i;
   assign w_stat = wr_any && (bus_addr_i == ADDR_W'(0));
   assign w_mask = wr_any && (bus_addr_i == ADDR_W'(4));
   assign w_en   = wr_any && (bus_addr_i == ADDR_W'(8));
   assign w_dis  = wr_any && (bus_addr_i == ADDR_W'(12));
   assign w_odd  = wr_any && (bus_addr_i[1:0] != 2'b00);
   assign rd_req = bus_vld_i && !bus_wr_i;

   p_masked_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((&mask_q) && $past(&mask_q)) |-> !irq_o);

   p_pending_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (((stat_q & ~mask_q) != '0) && $past((stat_q & ~mask_q) != '0)) |-> irq_o);

   p_evt_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

   p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (w_stat && evt_i == '0) |=> ((stat_q & $past(wlo)) == '0));

   p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (w_stat && ((wlo & evt_i) != '0)) |=> ((stat_q & $past(wlo & evt_i)) == $past(wlo & evt_i)));

   p_mask_ro_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      w_mask |=> $stable(mask_q));

   p_en_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      w_en |=> (((mask_q & $past(wlo)) == '0) &&
                ((mask_q & ~$past(wlo)) == ($past(mask_q) & ~$past(wlo)))));

   p_dis_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      w_dis |=> (((mask_q & $past(wlo)) == $past(wlo)) &&
                 ((mask_q & ~$past(wlo)) == ($past(mask_q) & ~$past(wlo)))));

   p_unaligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      w_odd |=> $stable(mask_q));

   p_rvld_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_req |=> bus_rvld_o);

   p_rvld_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_req |=> !bus_rvld_o);

endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
   .NUM_SRC (NUM_SRC),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .evt_i       (evt_i),
   .bus_vld_i   (bus_vld_i),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rvld_o  (bus_rvld_o),
   .irq_o       (irq_o),
   .stat_q      (stat_q),
   .mask_q      (mask_q)
);

// File: tb/tb_irq_mask_ctrl.sv
`timescale 1ns/1ps
module tb_irq_mask_ctrl;
   localparam int unsigned NS = 2;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] evt = '0;
   logic          vld = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rvld;
   logic          irq;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   irq_mask_ctrl #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .evt_i       (evt),
      .bus_vld_i   (vld),
      .bus_wr_i    (wr),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .bus_rvld_o  (rvld),
      .irq_o       (irq)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_op(input logic v, input logic w, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [NS-1:0] ev,
                         output logic [DW-1:0] rd, output logic rv);
      @(negedge clk);
      vld = v; wr = w; addr = a; wdata = d; evt = ev;
      @(negedge clk);
      rd = rdata; rv = rvld;
      vld = 1'b0; wr = 1'b0; evt = '0;
   endtask

   task automatic wr32(input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [DW-1:0] r; logic rv;
      bus_op(1'b1, 1'b1, a, d, '0, r, rv);
   endtask

   task automatic rd32(input logic [AW-1:0] a, output logic [DW-1:0] r);
      logic rv;
      bus_op(1'b1, 1'b0, a, '0, '0, r, rv);
      if (rv !== 1'b1) chk("R11 rvld", {31'd0, rv}, 32'd1);
   endtask

   task automatic pulse(input logic [NS-1:0] ev);
      logic [DW-1:0] r; logic rv;
      bus_op(1'b0, 1'b0, '0, '0, ev, r, rv);
   endtask

   task automatic set_state(input logic [NS-1:0] s, input logic [NS-1:0] m);
      wr32(6'h00, 32'h3);
      if (s != '0) pulse(s);
      wr32(6'h08, 32'h3);
      if (m != '0) wr32(6'h0C, DW'(m));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] r;
      logic          rv;
      repeat (3) @(negedge clk);
      chk("R1 irq in reset", {31'd0, irq}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq after reset", {31'd0, irq}, 32'd0);
      rd32(6'h00, r); chk("R1 status reset", r, 32'h0);
      rd32(6'h04, r); chk("R1 mask reset", r, 32'h3);

      // R11: valid lasts one cycle
      bus_op(1'b1, 1'b0, 6'h04, '0, '0, r, rv);
      chk("R11 rvld set", {31'd0, rv}, 32'd1);
      chk("R11 rdata", r, 32'h3);
      @(negedge clk);
      chk("R11 rvld single", {31'd0, rvld}, 32'd0);

      // R2, R3, R6: all status/mask combinations
      for (int s = 0; s < 4; s++) begin
         for (int m = 0; m < 4; m++) begin
            set_state(NS'(s), NS'(m));
            chk("R2 irq level", {31'd0, irq}, {31'd0, |(NS'(s) & ~NS'(m))});
            rd32(6'h00, r); chk("R3 status latched", r, DW'(s));
            rd32(6'h04, r); chk("R6 mask read", r, DW'(m));
         end
      end

      // R7, R8: every data pattern from every mask state
      for (int m = 0; m < 4; m++) begin
         for (int d = 0; d < 4; d++) begin
            set_state(2'b00, NS'(m));
            wr32(6'h08, DW'(d) | 32'hFFFF_FFF0);
            rd32(6'h04, r); chk("R7 enable clears", r, DW'(m & ~d & 3));
            set_state(2'b00, NS'(m));
            wr32(6'h0C, DW'(d));
            rd32(6'h04, r); chk("R8 disable sets", r, DW'(m | d));
         end
      end
      rd32(6'h08, r); chk("R7 enable reads zero", r, 32'h0);
      rd32(6'h0C, r); chk("R8 disable reads zero", r, 32'h0);

      // R4: clear patterns from every status state
      for (int s = 0; s < 4; s++) begin
         for (int d = 0; d < 4; d++) begin
            set_state(NS'(s), 2'b11);
            wr32(6'h00, DW'(d));
            rd32(6'h00, r); chk("R4 w1c", r, DW'(s & ~d & 3));
         end
      end

      // R5: event and clear on the same bit in the same cycle
      set_state(2'b00, 2'b00);
      bus_op(1'b1, 1'b1, 6'h00, 32'h3, 2'b01, r, rv);
      chk("R5 set wins irq", {31'd0, irq}, 32'd1);
      rd32(6'h00, r); chk("R5 set wins status", r, 32'h1);

      // R6: mask writes ignored
      set_state(2'b00, 2'b11);
      wr32(6'h04, 32'h0);
      rd32(6'h04, r); chk("R6 mask write ignored (ones)", r, 32'h3);
      set_state(2'b11, 2'b00);
      wr32(6'h04, 32'hFFFF_FFFF);
      rd32(6'h04, r); chk("R6 mask write ignored (zeros)", r, 32'h0);
      chk("R6 irq unchanged", {31'd0, irq}, 32'd1);

      // R9: unaligned accesses
      set_state(2'b11, 2'b11);
      wr32(6'h09, 32'h3);
      rd32(6'h04, r); chk("R9 unaligned write ignored", r, 32'h3);
      wr32(6'h01, 32'h3);
      rd32(6'h00, r); chk("R9 unaligned clear ignored", r, 32'h3);
      rd32(6'h01, r); chk("R9 unaligned read zero", r, 32'h0);
      rd32(6'h06, r); chk("R9 unaligned read zero", r, 32'h0);

      // R10: undefined offsets
      set_state(2'b01, 2'b10);
      for (int a = 16; a < 64; a += 4) begin
         wr32(AW'(a), 32'hFFFF_FFFF);
         rd32(AW'(a), r); chk("R10 undefined read zero", r, 32'h0);
      end
      rd32(6'h00, r); chk("R10 status unchanged", r, 32'h1);
      rd32(6'h04, r); chk("R10 mask unchanged", r, 32'h2);
      chk("R10 irq unchanged", {31'd0, irq}, 32'd1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule